// File: doc/BRIEF.md
# Flash Program/Erase Pulse Timer

This block sets how long each high-voltage step of an embedded flash controller lasts. Software loads an 8-bit duration setting and a 24-bit target address through a byte-wide write port, then fires one start strobe that names the operation: page program, page erase, bulk erase or verify. The block accepts the strobe only when it is idle. It raises a pulse-enable output for the whole operation and drops it when the time is up. The flash array and the charge pumps use the address and the pulse-enable.

The time base is a tick made by dividing the system clock by 128. A 10-bit counter counts ticks up to a limit. The limit is computed from the duration setting and the operation type when the start is accepted. Page program, page erase and verify last (setting+1)×256 system clock cycles. A bulk erase lasts twice that. While an operation runs, a completion flag is low. The flag rises on the same edge that the pulse ends, and that edge also sets a sticky interrupt request. The request stays set until software clears it.

Top module: `flash_pulse_timer`

## Requirements
- R1: After reset the duration setting reads 00h, the address output is 000000h, the completion flag is 1, the interrupt request is 0 and the pulse output is 0.
- R2: A write with select 0 loads the duration setting, which reads back at once. Selects 1, 2 and 3 load address bits [7:0], [15:8] and [23:16] of the address output.
- R3: A start strobe while idle lowers the completion flag, raises the pulse output and shows the operation code on the op output on the next cycle. The codes are 0 page program, 1 page erase, 2 bulk erase and 3 verify.
- R4: For operation codes 0, 1 and 3, the completion flag rises exactly (setting+1)×256 clock edges after the edge that accepted the start.
- R5: For operation code 2 (bulk erase), the completion flag rises exactly (setting+1)×512 clock edges after the accepting edge.
- R6: The completion flag and the pulse output are always opposite. The pulse ends on the edge where the flag rises.
- R7: The interrupt request is set on the edge where the completion flag rises. It then stays set until a cycle with the clear input high.
- R8: A start strobe that arrives while an operation runs is ignored. The op output and the end time of the running operation do not change.
- R9: The duration setting is sampled only when a start is accepted. Rewriting it during an operation changes the readback but not the running duration.
- R10: A clear that falls in the same cycle as the completion edge leaves the interrupt request set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 duration, 1 addr low, 2 addr mid, 3 addr high |
| wr_data | input | 8 | Write data byte |
| start_valid | input | 1 | Start strobe, one cycle |
| start_op | input | 2 | Operation code for the start |
| irq_clr | input | 1 | Clears the interrupt request |
| tcon_rd | output | 8 | Duration setting readback |
| flash_addr | output | 24 | Target address to the array |
| pulse_on | output | 1 | High-voltage pulse enable |
| op_kind | output | 2 | Code of the running or last operation |
| done | output | 1 | Completion flag, low while busy |
| irq | output | 1 | Sticky interrupt request |

## Verification
Some properties are checked on every cycle. The completion flag and the pulse output are always opposite. An accepted start takes effect on the next cycle. A start during an operation leaves the op code alone. The interrupt request is held and set on the completion edge. A cycle counter in the checker also compares every completion edge with the duration latched at the start.
Other behaviour only the bench scenarios can show: the exact readback after register writes, the address byte lanes, and the reset values. The same goes for a mid-operation rewrite of the setting and a clear that collides with completion. The full range of settings across the four operation types is likewise left to the scenarios.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_BULK   = 2'd2,
    OP_VERIFY = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SEL_TIME  = 2'd0,
    SEL_ALO   = 2'd1,
    SEL_AMID  = 2'd2,
    SEL_AHI   = 2'd3
  } sel_e;

  localparam int PAGE_SHIFT = 1;
  localparam int BULK_SHIFT = 2;
endpackage

// File: rtl/fpt_regs.sv
module fpt_regs #(
  parameter int TCON_W     = 8,
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [7:0]              wr_data,
  output logic [TCON_W-1:0]       tcon_q,
  output logic [8*ADDR_BYTES-1:0] addr_q
);
  import fpt_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcon_q <= '0;
    end else if (wr_en && wr_sel == SEL_TIME) begin
      tcon_q <= TCON_W'(wr_data);
    end
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[8*g +: 8] <= 8'h00;
      end else if (wr_en && wr_sel == 2'(g + 1)) begin
        addr_q[8*g +: 8] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/fpt_prescaler.sv
module fpt_prescaler #(
  parameter int DIV_LOG2 = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick = run && (div_q == '1);
endmodule

// File: rtl/fpt_seq.sv
module fpt_seq #(
  parameter int TCON_W = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic [1:0]        start_op,
  input  logic [TCON_W-1:0] tcon,
  input  logic              tick,
  input  logic              irq_clr,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic [1:0]        op_q
);
  import fpt_pkg::*;

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, limit_q, limit_n;
  logic [EXT_W-1:0] base, scaled;
  logic             finish;

  always_comb begin
    base    = EXT_W'(tcon) + EXT_W'(1);
    scaled  = (start_op == OP_BULK) ? (base << BULK_SHIFT) : (base << PAGE_SHIFT);
    limit_n = CNT_W'(scaled - EXT_W'(1));
  end

  assign accept = start_valid && !busy;
  assign finish = busy && tick && (cnt_q == limit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b1;
      cnt_q   <= '0;
      limit_q <= '0;
      op_q    <= OP_PROG;
    end else if (accept) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      cnt_q   <= '0;
      limit_q <= limit_n;
      op_q    <= start_op;
    end else if (finish) begin
      busy    <= 1'b0;
      done    <= 1'b1;
    end else if (busy && tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (finish) begin
      irq <= 1'b1;
    end else if (irq_clr) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
  parameter int TCON_W     = 8,
  parameter int CNT_W      = 10,
  parameter int DIV_LOG2   = 7,
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [7:0]              wr_data,
  input  logic                    start_valid,
  input  logic [1:0]              start_op,
  input  logic                    irq_clr,
  output logic [TCON_W-1:0]       tcon_rd,
  output logic [8*ADDR_BYTES-1:0] flash_addr,
  output logic                    pulse_on,
  output logic [1:0]              op_kind,
  output logic                    done,
  output logic                    irq
);
  logic accept, tick;

  fpt_regs #(.TCON_W(TCON_W), .ADDR_BYTES(ADDR_BYTES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tcon_q(tcon_rd), .addr_q(flash_addr)
  );

  fpt_prescaler #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk(clk), .rst(rst), .clear(accept), .run(pulse_on), .tick(tick)
  );

  fpt_seq #(.TCON_W(TCON_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_op(start_op),
    .tcon(tcon_rd), .tick(tick), .irq_clr(irq_clr), .accept(accept),
    .busy(pulse_on), .done(done), .irq(irq), .op_q(op_kind)
  );
endmodule

// File: rtl/flash_pulse_timer_sva.sv
module flash_pulse_timer_sva #(
  parameter int TCON_W   = 8,
  parameter int DIV_LOG2 = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start_valid,
  input logic [1:0]        start_op,
  input logic              irq_clr,
  input logic [TCON_W-1:0] tcon_rd,
  input logic              pulse_on,
  input logic [1:0]        op_kind,
  input logic              done,
  input logic              irq
);
  localparam int EW = TCON_W + DIV_LOG2 + 4;

  logic [EW-1:0] elapsed, expect_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed    <= '0;
      expect_len <= '0;
    end else if (start_valid && !pulse_on) begin
      elapsed    <= '0;
      expect_len <= (EW'(tcon_rd) + EW'(1)) << (DIV_LOG2 + ((start_op == 2'd2) ? 2 : 1));
    end else if (pulse_on) begin
      elapsed    <= elapsed + 1'b1;
    end
  end

  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (start_valid && !pulse_on) |=> (!done && pulse_on && op_kind == $past(start_op)));

  p_len_r4_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (elapsed == expect_len));

  p_flag_excl_r6: assert property (@(posedge clk) disable iff (rst)
    done != pulse_on);

  p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> irq);

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (pulse_on && start_valid) |=> $stable(op_kind));
endmodule

bind flash_pulse_timer flash_pulse_timer_sva #(.TCON_W(TCON_W), .DIV_LOG2(DIV_LOG2)) u_sva (
  .clk(clk), .rst(rst), .start_valid(start_valid), .start_op(start_op),
  .irq_clr(irq_clr), .tcon_rd(tcon_rd), .pulse_on(pulse_on), .op_kind(op_kind),
  .done(done), .irq(irq)
);

// File: tb/flash_pulse_timer_bench.sv
module flash_pulse_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'h00;
  logic        start_valid = 1'b0;
  logic [1:0]  start_op = 2'd0;
  logic        irq_clr = 1'b0;
  logic [7:0]  tcon_rd;
  logic [23:0] flash_addr;
  logic        pulse_on;
  logic [1:0]  op_kind;
  logic        done;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  flash_pulse_timer u_flash_pulse_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start_valid(start_valid), .start_op(start_op), .irq_clr(irq_clr),
    .tcon_rd(tcon_rd), .flash_addr(flash_addr), .pulse_on(pulse_on),
    .op_kind(op_kind), .done(done), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dur(input int op, input int t);
    return (t + 1) * ((op == 2) ? 512 : 256);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq == 1'b0, "R7 clear", irq, 0);
  endtask

  task automatic run_op(input int op, input int t, input bit inject);
    int d;
    d = dur(op, t);
    @(negedge clk);
    start_valid = 1'b1; start_op = 2'(op);
    @(negedge clk);
    start_valid = 1'b0;
    chk(!done && pulse_on && op_kind == 2'(op), "R3 start", {done, pulse_on, op_kind}, {2'b01, 2'(op)});
    if (inject) begin
      start_valid = 1'b1; start_op = 2'(op ^ 1);
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'hFF;
      @(negedge clk);
      start_valid = 1'b0; wr_en = 1'b0;
      chk(tcon_rd == 8'hFF, "R9 readback", tcon_rd, 8'hFF);
      repeat (d - 2) @(negedge clk);
      chk(op_kind == 2'(op), "R8 op kept", op_kind, op);
    end else begin
      repeat (d - 1) @(negedge clk);
    end
    chk(!done && pulse_on, (op == 2) ? "R5 not early" : "R4 not early", done, 0);
    @(negedge clk);
    chk(done && !pulse_on, (op == 2) ? "R5 end" : "R4 end", {done, pulse_on}, 2'b10);
    chk(irq == 1'b1, "R7 set", irq, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tcon_rd == 8'h00 && flash_addr == 24'h0, "R1 regs", {tcon_rd, flash_addr}, 0);
    chk(done && !pulse_on && !irq, "R1 flags", {done, pulse_on, irq}, 3'b100);

    wr(2'd3, 8'hA5); wr(2'd2, 8'h3C); wr(2'd1, 8'h71);
    chk(flash_addr == 24'hA53C71, "R2 addr", flash_addr, 24'hA53C71);
    wr(2'd0, 8'h03);
    chk(tcon_rd == 8'h03, "R2 tcon", tcon_rd, 3);

    run_op(0, 3, 1'b0);
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R7 hold", irq, 1);
    clear_irq();

    wr(2'd0, 8'h00);
    run_op(2, 0, 1'b0);
    clear_irq();

    wr(2'd0, 8'h02);
    run_op(1, 2, 1'b1);
    clear_irq();

    wr(2'd0, 8'h01);
    run_op(3, 1, 1'b0);
    clear_irq();

    // R10: clear collides with the completion edge
    wr(2'd0, 8'h00);
    @(negedge clk);
    start_valid = 1'b1; start_op = 2'd0;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (255) @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(done && irq, "R10 set wins", {done, irq}, 2'b11);
    clear_irq();

    wr(2'd0, 8'd63);
    run_op(0, 63, 1'b0);
    clear_irq();

    for (int i = 0; i < 8; i++) begin
      int op, t;
      logic [7:0] b;
      op = int'($urandom_range(3, 0));
      t  = int'($urandom_range(7, 0));
      b  = 8'($urandom);
      wr(2'd2, b);
      chk(flash_addr[15:8] == b, "R2 rand addr", flash_addr[15:8], b);
      wr(2'd0, 8'(t));
      run_op(op, t, (i % 3) == 0);
      clear_irq();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule